// File: doc/BRIEF.md
# Multi-source reset sequencing controller

This block gathers reset requests from seven sources: power-up, the external reset pin, a watchdog time-out, an internal halt monitor, loss of the clock reference, test mode and a CPU reset instruction. It drives four reset lines: the external pin reset, the clock-module reset, the master reset for the rest of the chip, and a system-reset flag that tells other logic the CPU executed a reset instruction. All requests are sampled on rising edges of the system clock.

Each source is either immediate or bus-aligned, and each maps to its own subset of lines. Immediate sources assert their lines on the first edge that samples them. Bus-aligned sources (clock loss and test mode) wait until the current bus cycle has ended. While one of them waits, a bus monitor runs and ends a hung cycle after a parameterised time-out. Once asserted, the lines are stretched for a fixed number of idle clocks and then all release on the same edge. A one-hot cause register holds the source of the most recent reset.

The request, bus and reset pins are plain level control signals with no handshake. There is no back-pressure: a request is honoured on the edge that samples it, or, for bus-aligned sources, as soon as the bus allows.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_i` is sampled high, `ext_rst_o`, `clk_rst_o` and `mst_rst_o` are high, `sys_rst_o` and `bus_term_o` are low, and `cause_o` equals 7'b0000001.
- R2: An immediate request (`ext_pin_i`, `wdog_i`, `halt_i`, `cpu_rst_i`) asserts its lines right after the first rising edge that samples it high, whatever the bus is doing.
- R3: The line sets, written {sys, mst, clk, ext}, are as follows. Power-up, external pin, watchdog, halt and clock loss each give 4'b0111. Test mode gives 4'b0101. The CPU reset instruction gives 4'b1001.
- R4: A bus-aligned request (`clk_loss_i`, `test_i`) asserts its lines on its first sampled edge when `bus_active_i` is low. When `bus_active_i` is high, it keeps its lines low until the edge that samples `bus_done_i` high, and asserts them right after that edge.
- R5: While a bus-aligned request waits on an active, unfinished cycle, the monitor counts edges. After the MON_LIMIT-th such edge (default 64), `bus_term_o` is high for exactly one cycle. The following edge grants the request. `bus_term_o` never pulses when no request is waiting.
- R6: When several requests are granted together or overlap, the asserted lines are the union of their sets.
- R7: After the last edge that samples a granted request, the lines stay unchanged through the next HOLD_CLKS (default 16) edges. They all fall together on the edge after those.
- R8: `cause_o` is one-hot, with bit order 0 power-up, 1 external pin, 2 watchdog, 3 halt, 4 clock loss, 5 test, 6 CPU instruction. It is loaded only on the edge where the lines go from all-low to asserted, and takes the lowest-numbered source granted on that edge. Requests that join an active reset leave it unchanged.
- R9: `cause_o` keeps its value after the lines release. Only a new reset changes it, and power-up sets it to bit 0 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every request is sampled on its rising edge |
| por_i | input | 1 | Power-up request, active high |
| ext_pin_i | input | 1 | External reset pin request, active high |
| wdog_i | input | 1 | Watchdog time-out request |
| halt_i | input | 1 | Halt monitor request (e.g. double bus fault) |
| clk_loss_i | input | 1 | Loss of clock reference request (bus-aligned) |
| test_i | input | 1 | Test-mode reset request (bus-aligned) |
| cpu_rst_i | input | 1 | CPU reset-instruction request |
| bus_active_i | input | 1 | A bus cycle is in progress |
| bus_done_i | input | 1 | The current bus cycle terminates normally this cycle |
| ext_rst_o | output | 1 | Reset to the external pin driver |
| clk_rst_o | output | 1 | Reset to the clock module |
| mst_rst_o | output | 1 | Master reset to all other internal logic |
| sys_rst_o | output | 1 | System-reset flag for a CPU reset instruction |
| bus_term_o | output | 1 | One-clock pulse that forces a hung bus cycle to end |
| cause_o | output | 7 | One-hot source of the most recent reset |

## Verification
Every line change is due one edge after the edge that samples its cause. Immediate and idle-bus requests show on the lines one clock after being driven. A waiting request shows one clock after `bus_done_i` is driven. A hung cycle gives a `bus_term_o` pulse after the 64th waiting edge, and the lines rise one edge after that. Release is due exactly on the 17th edge that samples no request. The bench drives inputs and samples outputs on falling edges, and counts falling edges from each stimulus so that every check lands on the cycle where the result is due.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int NSRC  = 7;
  localparam int NLINE = 4;

  localparam int SRC_POR  = 0;
  localparam int SRC_PIN  = 1;
  localparam int SRC_WDOG = 2;
  localparam int SRC_HALT = 3;
  localparam int SRC_CLKL = 4;
  localparam int SRC_TEST = 5;
  localparam int SRC_CPU  = 6;

  typedef logic [NLINE-1:0] lines_t;  // {sys, mst, clk, ext}

  localparam logic [NSRC-1:0] SYNC_SET = 7'b0110000;

  localparam logic [NSRC*NLINE-1:0] SRC_MASKS = {
    4'b1001,  // cpu instruction
    4'b0101,  // test mode
    4'b0111,  // clock loss
    4'b0111,  // halt
    4'b0111,  // watchdog
    4'b0111,  // external pin
    4'b0111   // power-up
  };
endpackage

// File: rtl/rst_src_decode.sv
module rst_src_decode
  import rst_seq_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  input  logic            sync_ok_i,
  output logic [NSRC-1:0] eff_o,
  output lines_t          mask_o,
  output logic [NSRC-1:0] pick_o,
  output logic            sync_req_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (SYNC_SET[g]) begin : g_sync
      assign eff_o[g] = req_i[g] & sync_ok_i;
    end else begin : g_async
      assign eff_o[g] = req_i[g];
    end
  end

  always_comb begin
    mask_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (eff_o[i]) mask_o = mask_o | SRC_MASKS[i*NLINE +: NLINE];
    end
  end

  // lowest index wins
  assign pick_o     = eff_o & (~eff_o + 1'b1);
  assign sync_req_o = |(req_i & SYNC_SET);
endmodule

// File: rtl/rst_bus_mon.sv
module rst_bus_mon #(
  parameter int MON_LIMIT = 64
) (
  input  logic clk,
  input  logic por_i,
  input  logic wait_i,
  output logic term_o
);
  localparam int CW = (MON_LIMIT > 2) ? $clog2(MON_LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(MON_LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (por_i) begin
      cnt_q  <= '0;
      term_o <= 1'b0;
    end else if (wait_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        term_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        term_o <= 1'b0;
      end
    end else begin
      cnt_q  <= '0;
      term_o <= 1'b0;
    end
  end

  // R5: single-cycle pulse, only for a waiting request
  a_r5_term_one_cycle: assert property (@(posedge clk) disable iff (por_i)
    term_o |=> !term_o);
  a_r5_term_only_waiting: assert property (@(posedge clk) disable iff (por_i)
    term_o |-> $past(wait_i));
endmodule

// File: rtl/rst_hold.sv
module rst_hold
  import rst_seq_pkg::*;
#(
  parameter int HOLD_CLKS = 16
) (
  input  logic   clk,
  input  logic   por_i,
  input  lines_t new_i,
  output lines_t lines_o,
  output logic   start_o,
  output logic   release_o
);
  localparam int HW = $clog2(HOLD_CLKS + 1);
  localparam logic [HW-1:0] LOAD = HW'(HOLD_CLKS);

  logic [HW-1:0] cnt_q;
  logic          any_new;

  assign any_new   = |new_i;
  assign start_o   = (lines_o == '0) && any_new;
  assign release_o = !any_new && (lines_o != '0) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (por_i) begin
      lines_o <= new_i;
      cnt_q   <= LOAD;
    end else if (any_new) begin
      lines_o <= lines_o | new_i;
      cnt_q   <= LOAD;
    end else if (release_o) begin
      lines_o <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: a request keeps every already-asserted line asserted
  a_r7_no_drop_on_req: assert property (@(posedge clk) disable iff (por_i)
    any_new |=> ((lines_o & $past(lines_o)) == $past(lines_o)));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int MON_LIMIT = 64,
  parameter int HOLD_CLKS = 16
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       ext_pin_i,
  input  logic       wdog_i,
  input  logic       halt_i,
  input  logic       clk_loss_i,
  input  logic       test_i,
  input  logic       cpu_rst_i,
  input  logic       bus_active_i,
  input  logic       bus_done_i,
  output logic       ext_rst_o,
  output logic       clk_rst_o,
  output logic       mst_rst_o,
  output logic       sys_rst_o,
  output logic       bus_term_o,
  output logic [6:0] cause_o
);
  logic [NSRC-1:0] req, eff, pick;
  lines_t          new_mask, lines;
  logic            sync_req, sync_ok, granted_q, start, release_now, mon_wait;

  assign req = {cpu_rst_i, test_i, clk_loss_i, halt_i, wdog_i, ext_pin_i, por_i};

  assign sync_ok  = !bus_active_i || bus_done_i || bus_term_o || granted_q;
  assign mon_wait = sync_req && !sync_ok;

  rst_src_decode u_dec (
    .req_i      (req),
    .sync_ok_i  (sync_ok),
    .eff_o      (eff),
    .mask_o     (new_mask),
    .pick_o     (pick),
    .sync_req_o (sync_req)
  );

  rst_bus_mon #(.MON_LIMIT(MON_LIMIT)) u_mon (
    .clk    (clk),
    .por_i  (por_i),
    .wait_i (mon_wait),
    .term_o (bus_term_o)
  );

  rst_hold #(.HOLD_CLKS(HOLD_CLKS)) u_hold (
    .clk       (clk),
    .por_i     (por_i),
    .new_i     (new_mask),
    .lines_o   (lines),
    .start_o   (start),
    .release_o (release_now)
  );

  always_ff @(posedge clk) begin
    if (por_i || release_now) granted_q <= 1'b0;
    else if (|(eff & SYNC_SET)) granted_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por_i)      cause_o <= 7'b0000001;
    else if (start) cause_o <= pick;
  end

  assign ext_rst_o = lines[0];
  assign clk_rst_o = lines[1];
  assign mst_rst_o = lines[2];
  assign sys_rst_o = lines[3];

  // R2: immediate sources act on the next edge
  a_r2_async_now: assert property (@(posedge clk) disable iff (por_i)
    (ext_pin_i || wdog_i || halt_i) |=> (ext_rst_o && clk_rst_o && mst_rst_o));
  // R3: CPU instruction drives pin reset and the system flag
  a_r3_cpu_lines: assert property (@(posedge clk) disable iff (por_i)
    cpu_rst_i |=> (ext_rst_o && sys_rst_o));
  // R4: a lone test request waits for a busy bus
  a_r4_sync_holds_off: assert property (@(posedge clk) disable iff (por_i)
    (test_i && !ext_rst_o && !ext_pin_i && !wdog_i && !halt_i && !clk_loss_i &&
     !cpu_rst_i && bus_active_i && !bus_done_i && !bus_term_o) |=> !ext_rst_o);
  // R7: every set contains the pin line, so all lines release with it
  a_r7_release_together: assert property (@(posedge clk) disable iff (por_i)
    !ext_rst_o |-> (!clk_rst_o && !mst_rst_o && !sys_rst_o));
  // R8: cause is one-hot and frozen while a reset is active
  a_r8_cause_onehot: assert property (@(posedge clk) disable iff (por_i)
    $onehot(cause_o));
  a_r8_cause_frozen: assert property (@(posedge clk) disable iff (por_i)
    $past(ext_rst_o) |-> $stable(cause_o));
endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [6:0] req = '0;  // {cpu,test,clkloss,halt,wdog,pin,por}
  logic bus_active = 1'b0, bus_done = 1'b0;
  logic ext_rst, clk_rst, mst_rst, sys_rst, bus_term;
  logic [6:0] cause;
  int errors = 0, checks = 0;
  bit finished = 0;

  rst_seq_ctrl dut_i (
    .clk(clk), .por_i(req[0]), .ext_pin_i(req[1]), .wdog_i(req[2]),
    .halt_i(req[3]), .clk_loss_i(req[4]), .test_i(req[5]), .cpu_rst_i(req[6]),
    .bus_active_i(bus_active), .bus_done_i(bus_done),
    .ext_rst_o(ext_rst), .clk_rst_o(clk_rst), .mst_rst_o(mst_rst),
    .sys_rst_o(sys_rst), .bus_term_o(bus_term), .cause_o(cause)
  );

  function automatic logic [3:0] lines();
    return {sys_rst, mst_rst, clk_rst, ext_rst};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // requests already removed: 16 held edges, drop on the 17th
  task automatic hold_drop(logic [3:0] m);
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk); chk("R7 held", 32'(lines()), 32'(m));
    end
    @(negedge clk); chk("R7 release", 32'(lines()), 0);
  endtask

  task automatic pulse(int idx, int len, logic [3:0] m, logic [6:0] c, string tag);
    req[idx] = 1'b1;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk); chk(tag, 32'(lines()), 32'(m));
    end
    req[idx] = 1'b0;
    chk("R8 cause", 32'(cause), 32'(c));
    hold_drop(m);
    chk("R9 cause kept", 32'(cause), 32'(c));
  endtask

  initial begin
    req[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 lines", 32'(lines()), 32'h7);
    chk("R1 cause", 32'(cause), 32'h1);
    chk("R1 term", 32'(bus_term), 0);
    req[0] = 1'b0;
    hold_drop(4'b0111);
    chk("R9 cause after por", 32'(cause), 32'h1);

    pulse(1, 1, 4'b0111, 7'h02, "R2 R3 pin");
    pulse(2, 3, 4'b0111, 7'h04, "R2 R3 wdog");
    pulse(3, 2, 4'b0111, 7'h08, "R2 R3 halt");
    pulse(6, 2, 4'b1001, 7'h40, "R2 R3 cpu");
    bus_active = 1'b1; bus_done = 1'b1;
    pulse(2, 1, 4'b0111, 7'h04, "R2 wdog on busy bus");
    bus_active = 1'b0; bus_done = 1'b0;
    pulse(4, 1, 4'b0111, 7'h10, "R4 R3 clkloss idle");
    pulse(5, 2, 4'b0101, 7'h20, "R4 R3 test idle");

    // R4: wait for bus_done
    bus_active = 1'b1; req[5] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk("R4 wait", 32'(lines()), 0);
    end
    bus_done = 1'b1;
    @(negedge clk); chk("R4 on done", 32'(lines()), 32'h5);
    bus_done = 1'b0; bus_active = 1'b0; req[5] = 1'b0;
    chk("R8 test cause", 32'(cause), 32'h20);
    hold_drop(4'b0101);

    // R5: hung bus cycle
    bus_active = 1'b1; req[4] = 1'b1;
    for (int k = 1; k <= 63; k++) begin
      @(negedge clk);
      chk("R5 no term yet", 32'(bus_term), 0);
      chk("R5 lines wait", 32'(lines()), 0);
    end
    @(negedge clk);
    chk("R5 term pulse", 32'(bus_term), 1);
    chk("R5 lines before grant", 32'(lines()), 0);
    @(negedge clk);
    chk("R5 term ends", 32'(bus_term), 0);
    chk("R5 granted", 32'(lines()), 32'h7);
    req[4] = 1'b0; bus_active = 1'b0;
    hold_drop(4'b0111);

    // R6: union and priority
    req[2] = 1'b1; req[6] = 1'b1;
    @(negedge clk);
    chk("R6 union wdog cpu", 32'(lines()), 32'hF);
    chk("R8 priority wdog", 32'(cause), 32'h04);
    req[2] = 1'b0; req[6] = 1'b0;
    hold_drop(4'hF);
    req[3] = 1'b1; req[5] = 1'b1;
    @(negedge clk);
    chk("R6 union halt test", 32'(lines()), 32'h7);
    chk("R8 priority halt", 32'(cause), 32'h08);
    req[3] = 1'b0; req[5] = 1'b0;
    hold_drop(4'h7);

    // R8: joining request leaves the cause alone
    req[1] = 1'b1;
    @(negedge clk); req[1] = 1'b0;
    repeat (3) @(negedge clk);
    req[6] = 1'b1;
    @(negedge clk);
    chk("R6 joined lines", 32'(lines()), 32'hF);
    chk("R8 cause unchanged", 32'(cause), 32'h02);
    req[6] = 1'b0;
    hold_drop(4'hF);
    chk("R9 cause kept", 32'(cause), 32'h02);

    req[0] = 1'b1;
    @(negedge clk);
    chk("R9 por resets cause", 32'(cause), 32'h01);
    chk("R1 lines por", 32'(lines()), 32'h7);
    req[0] = 1'b0;
    hold_drop(4'h7);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule